// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Timing Generator

This block produces the row-scan timing for a multiplexed dot-matrix LCD driver with 32 row-capable outputs. It runs on the oscillator-rate clock. A prescaler turns that clock into a cascade clock, which is sent to companion column drivers. A row sequencer steps through the rows of the selected multiplex rate and marks the first clock of each frame with a sync pulse. The frame lasts 192 oscillator clocks at every multiplex rate, so the frame rate stays the same when the rate changes.

A decoder turns the scan row into a 32-bit row-select vector. At the two lower multiplex rates the select is copied onto several output groups at once, so that a split screen can be driven. The decoder also reports which of the three programmable 8-output groups act as rows. A logical RAM row index is produced as well. It is the scan row offset by the start bank, which lets the display scroll by whole 8-row banks.

Top module: `lcd_scan_timing`

## Requirements
- R1: `casc_clk_o` has a period of 6 oscillator clocks, or 8 when the active rate is 1:24. It is high for the first half of each period. Every period starts at a frame start or at the end of reset.
- R2: `mux_sel_i` encodes the rate as 0 = 1:8, 1 = 1:16, 2 = 1:24 and 3 = 1:32. The scan row starts at 0 and advances by one per cascade period at 1:24 and 1:32, per 2 periods at 1:16 and per 4 periods at 1:8. It stays below the row count of the rate (8, 16, 24 or 32).
- R3: Every frame is 192 oscillator clocks long. `frame_sync_o` is high for exactly the first clock of each frame after the first, when the scan row is 0.
- R4: At 1:24 and 1:32, exactly one bit of `row_sel_o` is set, and its index equals the scan row.
- R5: At 1:16, bit k and bit k+16 are selected together. At 1:8, bits k, k+8, k+16 and k+24 are selected together. Each copy appears only where its group is a row group.
- R6: Outputs 0 to 7 are always rows. While the scan row is below 8, exactly one of them is selected.
- R7: Bit g of `grp_is_row_o` covers outputs 8(g+1) to 8(g+1)+7. In row mode (`row_mode_i` = 1) all three bits are 1. In mixed mode a bit is 1 only when its group lies below the row count of the active rate. Column groups carry no select.
- R8: `row_idx_o` equals (scan row + 8 × `start_bank_i`) mod 32. A change of bank shows in the same cycle.
- R9: While `rst_ni` is low, the scan row is 0 at rate 1:32, `row_sel_o` selects output 0 only, `frame_sync_o` is 0 and `casc_clk_o` is 1.
- R10: `mux_sel_i` is sampled only on the last clock of a frame. The sampled rate governs the whole of the next frame, so a change in mid-frame has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mux_sel_i | input | 2 | Requested multiplex rate |
| row_mode_i | input | 1 | 1 = all programmable groups are rows, 0 = mixed mode |
| start_bank_i | input | 2 | RAM bank mapped to the top display row |
| casc_clk_o | output | 1 | Divided clock for cascaded column drivers |
| frame_sync_o | output | 1 | One-clock pulse at the start of each frame |
| row_sel_o | output | 32 | Row-select vector, one bit per output |
| row_idx_o | output | 5 | Logical RAM row for the current scan row |
| grp_is_row_o | output | 3 | Programmable groups currently acting as rows |

## Verification
The assertions check the following on every cycle:
- the prescaler count stays inside the divide ratio;
- the scan row moves only on a cascade tick and stays in range;
- the latched rate holds between frame boundaries;
- the sync pulse lasts one clock and lands on row 0;
- the select count matches the rate and mode.

Some properties need the bench's scenarios. These are the fixed 192-clock frame length across all four rates, the deferred effect of a rate change made mid-frame, the placement of the replicated selects under mixed and row mode, and the bank offset on the row index. The bench shows them by comparing every output on every clock against a behavioural model.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    MUX_8  = 2'd0,
    MUX_16 = 2'd1,
    MUX_24 = 2'd2,
    MUX_32 = 2'd3
  } mux_e;

  localparam int unsigned NUM_OUT = 32;
  localparam int unsigned GRP_W   = 8;
  localparam int unsigned NUM_GRP = NUM_OUT / GRP_W;
  localparam int unsigned ROW_W   = $clog2(NUM_OUT);
  localparam int unsigned BANK_W  = ROW_W - $clog2(GRP_W);
  localparam int unsigned DIV_STD = 6;
  localparam int unsigned DIV_ALT = 8;
  localparam mux_e        MUX_RST = MUX_32;

  function automatic int unsigned rows_of(mux_e m);
    return (int'(m) + 1) * GRP_W;
  endfunction

  // 1:24 fills a frame with 24 ticks at /8; others use NUM_OUT ticks at /6
  function automatic int unsigned ticks_per_row(mux_e m);
    return (m == MUX_24) ? 1 : NUM_OUT / rows_of(m);
  endfunction

  function automatic int unsigned div_of(mux_e m);
    return (m == MUX_24) ? DIV_ALT : DIV_STD;
  endfunction
endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter  int unsigned MAX_DIV = 8,
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             casc_clk_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o     = (cnt_q == div_i - 1'b1);
  assign casc_clk_o = (cnt_q < (div_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_ratio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       mux_sel_i,
  output mux_e             cur_mux_o,
  output logic [ROW_W-1:0] row_o,
  output logic             frame_sync_o
);
  localparam int unsigned SUB_W = $clog2(NUM_GRP);

  mux_e             cur_q;
  logic [ROW_W-1:0] row_q, row_lim;
  logic [SUB_W-1:0] sub_q, sub_lim;
  logic             sync_q, row_last, sub_last, frame_end;

  always_comb begin
    row_lim = ROW_W'(rows_of(cur_q) - 1);
    sub_lim = SUB_W'(ticks_per_row(cur_q) - 1);
  end

  assign row_last  = (row_q == row_lim);
  assign sub_last  = (sub_q == sub_lim);
  assign frame_end = tick_i && row_last && sub_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= MUX_RST;
      row_q  <= '0;
      sub_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= frame_end;
      if (frame_end) begin
        cur_q <= mux_e'(mux_sel_i);
        row_q <= '0;
        sub_q <= '0;
      end else if (tick_i) begin
        if (sub_last) begin
          sub_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign cur_mux_o    = cur_q;
  assign row_o        = row_q;
  assign frame_sync_o = sync_q;

  p_row_moves_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(row_q));
  p_row_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(row_q) < int'(rows_of(cur_q)));
  p_sync_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |=> !sync_q);
  p_sync_at_row0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> (row_q == '0 && sub_q == '0));
  p_rate_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(cur_q));
endmodule

// File: rtl/lcd_row_decode.sv
module lcd_row_decode
  import lcd_scan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mux_e               cur_mux_i,
  input  logic               row_mode_i,
  input  logic [ROW_W-1:0]   row_i,
  output logic [NUM_OUT-1:0] row_sel_o,
  output logic [NUM_GRP-2:0] grp_is_row_o
);
  logic [NUM_GRP-1:0] is_row;

  assign is_row[0] = 1'b1;

  for (genvar g = 1; g < NUM_GRP; g++) begin : g_grp
    assign is_row[g] = row_mode_i || (g * GRP_W < rows_of(cur_mux_i));
  end

  assign grp_is_row_o = is_row[NUM_GRP-1:1];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic hit;
    always_comb begin
      unique case (cur_mux_i)
        MUX_8:   hit = (row_i == ROW_W'(i % GRP_W));
        MUX_16:  hit = (row_i == ROW_W'(i % (2 * GRP_W)));
        default: hit = (row_i == ROW_W'(i));
      endcase
    end
    assign row_sel_o[i] = hit && is_row[i / GRP_W];
  end

  p_single_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mux_i == MUX_24 || cur_mux_i == MUX_32) |-> $countones(row_sel_o) == 1);
  p_split_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mux_i == MUX_16 && row_mode_i) |-> $countones(row_sel_o) == 2);
  p_quad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mux_i == MUX_8 && row_mode_i) |-> $countones(row_sel_o) == 4);
  p_base_rows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(row_i) < GRP_W) |-> $countones(row_sel_o[GRP_W-1:0]) == 1);
  p_row_mode_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_mode_i |-> &grp_is_row_o);
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mux_sel_i,
  input  logic               row_mode_i,
  input  logic [BANK_W-1:0]  start_bank_i,
  output logic               casc_clk_o,
  output logic               frame_sync_o,
  output logic [NUM_OUT-1:0] row_sel_o,
  output logic [ROW_W-1:0]   row_idx_o,
  output logic [NUM_GRP-2:0] grp_is_row_o
);
  localparam int unsigned DIV_W = $clog2(DIV_ALT + 1);
  localparam int unsigned OFF_W = ROW_W - BANK_W;

  mux_e             cur_mux;
  logic             tick;
  logic [DIV_W-1:0] div_val;
  logic [ROW_W-1:0] scan_row;

  assign div_val = DIV_W'(div_of(cur_mux));

  lcd_prescaler #(.MAX_DIV(DIV_ALT)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_val),
    .tick_o     (tick),
    .casc_clk_o (casc_clk_o)
  );

  lcd_row_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .mux_sel_i    (mux_sel_i),
    .cur_mux_o    (cur_mux),
    .row_o        (scan_row),
    .frame_sync_o (frame_sync_o)
  );

  lcd_row_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cur_mux_i    (cur_mux),
    .row_mode_i   (row_mode_i),
    .row_i        (scan_row),
    .row_sel_o    (row_sel_o),
    .grp_is_row_o (grp_is_row_o)
  );

  // bank offset wraps modulo the row space
  assign row_idx_o = scan_row + {start_bank_i, {OFF_W{1'b0}}};
endmodule

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb;
  localparam int CLK_P   = 10;
  localparam int FRAME   = 192;
  localparam int WD_CYC  = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mux_sel_i = 2'd3;
  logic        row_mode_i = 1'b0;
  logic [1:0]  start_bank_i = 2'd0;
  logic        casc_clk_o, frame_sync_o;
  logic [31:0] row_sel_o;
  logic [4:0]  row_idx_o;
  logic [2:0]  grp_is_row_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int pos = 0;
  int m   = 3;
  int syn = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  lcd_scan_timing u_dut (
    .clk_i, .rst_ni, .mux_sel_i, .row_mode_i, .start_bank_i,
    .casc_clk_o, .frame_sync_o, .row_sel_o, .row_idx_o, .grp_is_row_o
  );

  // behavioural reference: position in a fixed 192-clock frame
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos = 0; m = 3; syn = 0;
    end else if (pos == FRAME - 1) begin
      pos = 0; m = int'(mux_sel_i); syn = 1;
    end else begin
      pos = pos + 1; syn = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int dv, rpt, row, rows;
    bit [2:0]  grp;
    bit [31:0] sel;
    bit        casc;
    string     tg;
    dv   = (m == 2) ? 8 : 6;
    rpt  = (m == 0) ? 4 : (m == 1) ? 2 : 1;
    rows = 8 * (m + 1);
    row  = (pos / dv) / rpt;
    casc = (pos % dv) < dv / 2;
    for (int g = 0; g < 3; g++) grp[g] = row_mode_i || (8 * (g + 1) < rows);
    for (int i = 0; i < 32; i++) begin
      bit isr, hit;
      isr = (i < 8) || grp[i/8 - 1];
      hit = (m == 0) ? (i % 8 == row) : (m == 1) ? (i % 16 == row) : (i == row);
      sel[i] = isr && hit;
    end
    chk(casc_clk_o == casc, "R1 cascade clock", casc_clk_o, casc);
    chk(frame_sync_o == (syn != 0), "R3 frame sync", frame_sync_o, syn);
    tg = (int'(mux_sel_i) != m) ? "R10 rate deferred" : (m >= 2) ? "R4 single select" : "R5 replicated select";
    chk(row_sel_o == sel, tg, row_sel_o, sel);
    chk(row_sel_o[7:0] == sel[7:0], "R6 base rows", row_sel_o[7:0], sel[7:0]);
    chk(grp_is_row_o == grp, "R7 group roles", grp_is_row_o, grp);
    chk(int'(row_idx_o) == (row + 8 * int'(start_bank_i)) % 32,
        (start_bank_i == 0) ? "R2 scan row" : "R8 bank offset",
        row_idx_o, (row + 8 * int'(start_bank_i)) % 32);
  endtask

  task automatic run(input int cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk_i);
      #1 compare_all();
    end
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    start_bank_i = 2'd2;
    repeat (3) @(negedge clk_i);
    #1;
    // R9 reset state
    chk(row_sel_o == 32'h1, "R9 reset select", row_sel_o, 32'h1);
    chk(frame_sync_o == 1'b0, "R9 reset sync", frame_sync_o, 0);
    chk(casc_clk_o == 1'b1, "R9 reset casc", casc_clk_o, 1);
    chk(row_idx_o == 5'd16, "R9 reset index", row_idx_o, 16);
    chk(grp_is_row_o == 3'b111, "R9 reset groups", grp_is_row_o, 3'b111);
    start_bank_i = 2'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 compare_all();

    run(400);                                  // 1:32 mixed
    mux_sel_i = 2'd0; start_bank_i = 2'd1;     // change mid-frame (R10)
    run(450);
    row_mode_i = 1'b1; mux_sel_i = 2'd1;
    run(100);
    start_bank_i = 2'd3;
    run(300);
    mux_sel_i = 2'd2; row_mode_i = 1'b0;
    run(250);
    row_mode_i = 1'b1;
    run(200);
    mux_sel_i = 2'd0;
    run(400);
    row_mode_i = 1'b0; mux_sel_i = 2'd1; start_bank_i = 2'd0;
    run(400);
    mux_sel_i = 2'd3;
    run(250);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule